// File: doc/BRIEF.md
# Interrupt Capture and Masking Unit

This unit gathers twelve single-cycle event pulses from a communication controller core and turns them into sticky status flags that software can inspect and acknowledge. Two independent controls govern each source: an enable vector decides whether a pulse is captured into status at all, and a mask vector decides whether a captured flag is allowed to drive the single interrupt line towards the processor. A masked flag is still recorded, so software can poll it without being interrupted.

Software reaches the unit through a plain 32-bit register port with a write strobe, a word address, byte enables and a combinational read path. The enable and mask vectors are never written directly. Each one has a set address and a clear address, and writing ones at either address touches only the selected bits. Status flags are acknowledged by writing ones to them. All twelve source bits sit in the low half-word: byte lane 0 carries bits 7:0 and byte lane 1 carries bits 11:8.

Top module: `irq_capture_unit`

## Requirements
- R1: After reset, status, enable and mask are all zero, reads at word addresses 0, 1 and 3 return 0, and irq_o is 0.
- R2: A write at word address 1 sets every enable bit whose write-data bit is 1. A write at word address 2 clears every enable bit whose write-data bit is 1. Bits written as 0 keep their value, and a read at address 1 returns the enable vector in bits 11:0.
- R3: A write at word address 3 sets mask bits and a write at word address 4 clears mask bits, with the same per-bit rules as R2. A read at address 3 returns the mask vector in bits 11:0.
- R4: A 1 on evt_i[k] during a cycle in which enable bit k already holds 1 sets status bit k at that clock edge, and the bit stays set. A pulse on a disabled source, including one that arrives in the same cycle as the write that enables it, is ignored. A read at address 0 returns status in bits 11:0. The source order, from bit 0 upwards, is: receive, transmit, error warning, data overrun, error passive, arbitration lost, bus error, logger finished, receive buffer full, bit rate shift, receive buffer not empty, transmit buffer hardware command.
- R5: Writing 1 to a bit at word address 0 clears that status bit. Writing 0 leaves the bit unchanged.
- R6: If an enabled event arrives in the same cycle as a write-one-to-clear of the same status bit, the bit stays set.
- R7: irq_o is a register. One clock edge after the state changes, it equals the OR over all bits of status AND NOT mask.
- R8: A mask bit of 1 does not prevent the corresponding event from being captured into status.
- R9: Byte lane 0 (be_i[0]) gates write bits 7:0 and lane 1 (be_i[1]) gates write bits 11:8. A write whose lane is off leaves those bits unchanged. Read bits 31:12 are always 0, and reads at addresses 2 and 4 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 12 | Single-cycle event pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Word address of the register access |
| be_i | input | 4 | Byte enables for the write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A write or an event applied in one cycle changes status, enable or mask at the next rising edge. The bench drives each stimulus at a falling edge, lets exactly one rising edge pass and reads the register back at the next falling edge, because the read path is combinational. irq_o lags the state it summarises by one more edge, so every interrupt check follows one extra idle cycle. The expected value is taken from the bench's model of status and mask as it stood after the stimulus. Sweeps cover every source bit for capture, masking and clearing, and they also cover both byte lanes, the same-cycle event-and-clear collision and the same-cycle enable-and-event case.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_SRC = 12;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int BE_W    = DATA_W / 8;

    // Source positions within every interrupt vector
    localparam int SRC_RX       = 0;
    localparam int SRC_TX       = 1;
    localparam int SRC_ERR_WARN = 2;
    localparam int SRC_OVERRUN  = 3;
    localparam int SRC_ERR_PASV = 4;
    localparam int SRC_ARB_LOST = 5;
    localparam int SRC_BUS_ERR  = 6;
    localparam int SRC_LOG_DONE = 7;
    localparam int SRC_RX_FULL  = 8;
    localparam int SRC_BRS      = 9;
    localparam int SRC_RX_AVAIL = 10;
    localparam int SRC_TXB_CMD  = 11;

    typedef enum logic [ADDR_W-1:0] {
        ADR_STATUS  = 3'd0,
        ADR_EN_SET  = 3'd1,
        ADR_EN_CLR  = 3'd2,
        ADR_MSK_SET = 3'd3,
        ADR_MSK_CLR = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic stat_clr;
        logic en_set;
        logic en_clr;
        logic msk_set;
        logic msk_clr;
    } wr_sel_t;

    function automatic wr_sel_t decode_sel(input logic we, input logic [ADDR_W-1:0] a);
        wr_sel_t s;
        s = '0;
        if (we) begin
            case (reg_addr_e'(a))
                ADR_STATUS:  s.stat_clr = 1'b1;
                ADR_EN_SET:  s.en_set   = 1'b1;
                ADR_EN_CLR:  s.en_clr   = 1'b1;
                ADR_MSK_SET: s.msk_set  = 1'b1;
                ADR_MSK_CLR: s.msk_clr  = 1'b1;
                default:     s = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/irqc_setclr.sv
module irqc_setclr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q | set_i) & ~clr_i;
    end

    assign q_o = q;
endmodule

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] flag;

    for (genvar k = 0; k < W; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)                      flag[k] <= 1'b0;
            else if (evt_i[k] && en_i[k]) flag[k] <= 1'b1;   // new event beats the clear
            else if (clr_i[k])            flag[k] <= 1'b0;
        end
    end

    assign q_o = flag;
endmodule

// File: rtl/irqc_wdecode.sv
module irqc_wdecode
    import irqc_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic [DATA_W-1:0] wdata_i,
    output wr_sel_t           sel_o,
    output logic [N-1:0]      bits_o
);
    assign sel_o = decode_sel(wr_en_i, addr_i);

    for (genvar k = 0; k < N; k++) begin : g_lane
        assign bits_o[k] = wdata_i[k] & be_i[k/8];
    end
endmodule

// File: rtl/irq_capture_unit.sv
module irq_capture_unit
    import irqc_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      evt_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    wr_sel_t      sel;
    logic [N-1:0] wbits;
    logic [N-1:0] status_q;
    logic [N-1:0] en_q;
    logic [N-1:0] mask_q;
    logic         irq_q;

    irqc_wdecode #(.N(N)) u_dec (
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .be_i    (be_i),
        .wdata_i (wdata_i),
        .sel_o   (sel),
        .bits_o  (wbits)
    );

    irqc_setclr #(.W(N)) u_enable (
        .clk   (clk),
        .rst   (rst),
        .set_i (sel.en_set ? wbits : '0),
        .clr_i (sel.en_clr ? wbits : '0),
        .q_o   (en_q)
    );

    irqc_setclr #(.W(N)) u_mask (
        .clk   (clk),
        .rst   (rst),
        .set_i (sel.msk_set ? wbits : '0),
        .clr_i (sel.msk_clr ? wbits : '0),
        .q_o   (mask_q)
    );

    irqc_capture #(.W(N)) u_status (
        .clk   (clk),
        .rst   (rst),
        .evt_i (evt_i),
        .en_i  (en_q),
        .clr_i (sel.stat_clr ? wbits : '0),
        .q_o   (status_q)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(status_q & ~mask_q);
    end

    assign irq_o = irq_q;

    always_comb begin
        rdata_o = '0;
        case (reg_addr_e'(addr_i))
            ADR_STATUS:  rdata_o[N-1:0] = status_q;
            ADR_EN_SET:  rdata_o[N-1:0] = en_q;
            ADR_MSK_SET: rdata_o[N-1:0] = mask_q;
            default:     rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input logic              clk,
    input logic              rst,
    input logic [N-1:0]      evt_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [BE_W-1:0]   be_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              irq_o,
    input logic [N-1:0]      status_q,
    input logic [N-1:0]      en_q,
    input logic [N-1:0]      mask_q
);
    logic [N-1:0] wb;
    logic [N-1:0] cap;

    always_comb begin
        for (int k = 0; k < N; k++) wb[k] = wdata_i[k] & be_i[k/8];
    end
    assign cap = evt_i & en_q;

    p_en_set_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == ADR_EN_SET) |=> ((en_q & $past(wb)) == $past(wb)));
    p_en_clr_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == ADR_EN_CLR) |=> ((en_q & $past(wb)) == '0));
    p_msk_set_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == ADR_MSK_SET) |=> ((mask_q & $past(wb)) == $past(wb)));
    p_msk_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == ADR_MSK_CLR) |=> ((mask_q & $past(wb)) == '0));
    p_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(cap)) == '0));
    p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == ADR_STATUS) |=> ((status_q & $past(wb & ~cap)) == '0));
    p_evt_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (cap != '0) |=> ((status_q & $past(cap)) == $past(cap)));
    p_irq_follow_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == |($past(status_q) & ~$past(mask_q))));
    p_upper_zero_r9: assert property (@(posedge clk) disable iff (rst)
        rdata_o[DATA_W-1:N] == '0);
endmodule

bind irq_capture_unit irqc_checker #(.N(N)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .evt_i    (evt_i),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .be_i     (be_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .irq_o    (irq_o),
    .status_q (status_q),
    .en_q     (en_q),
    .mask_q   (mask_q)
);

// File: tb/irq_capture_unit_tb.sv
module irq_capture_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] evt = '0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    logic [11:0] en_m = '0, mk_m = '0, st_m = '0;

    always #2 clk = ~clk;

    irq_capture_unit u_dut (
        .clk(clk), .rst(rst), .evt_i(evt), .wr_en_i(we), .addr_i(addr),
        .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle of stimulus: optional write plus event pulses, model updated from the requirements
    task automatic step(input logic w, input logic [2:0] a, input logic [3:0] b,
                        input logic [31:0] d, input logic [11:0] ev);
        logic [11:0] lanes, wb, cap;
        @(negedge clk);
        we = w; addr = a; be = b; wdata = d; evt = ev;
        lanes = {{4{b[1]}}, {8{b[0]}}};
        wb = d[11:0] & lanes;
        cap = ev & en_m;
        if (w) begin
            case (a)
                3'd0: st_m = st_m & ~wb;
                3'd1: en_m = en_m | wb;
                3'd2: en_m = en_m & ~wb;
                3'd3: mk_m = mk_m | wb;
                3'd4: mk_m = mk_m & ~wb;
                default: ;
            endcase
        end
        st_m = st_m | cap;
        @(negedge clk);
        we = 1'b0; evt = '0; be = '0; wdata = '0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic irq_chk(input string req);
        @(negedge clk);
        check(req, {31'd0, irq}, {31'd0, |(st_m & ~mk_m)});
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd("R1 status", 3'd0, 32'h0);
        rd("R1 enable", 3'd1, 32'h0);
        rd("R1 mask", 3'd3, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);

        // R9 byte lanes on enable, R2 set/clear
        step(1, 3'd1, 4'h0, 32'hFFF, '0); rd("R9 no lanes", 3'd1, {20'd0, en_m});
        step(1, 3'd1, 4'h1, 32'hFFF, '0); rd("R9 lane0", 3'd1, {20'd0, en_m});
        step(1, 3'd1, 4'h2, 32'hFFF, '0); rd("R2 set all", 3'd1, {20'd0, en_m});
        step(1, 3'd2, 4'h1, 32'h0F0, '0); rd("R2 clear", 3'd1, {20'd0, en_m});
        rd("R9 en_clr reads 0", 3'd2, 32'h0);
        step(1, 3'd2, 4'h3, 32'hFFF, '0); rd("R2 clear all", 3'd1, 32'h0);

        // R3 mask set/clear
        step(1, 3'd3, 4'h3, 32'hA5C, '0); rd("R3 set", 3'd3, {20'd0, mk_m});
        step(1, 3'd4, 4'h2, 32'hF00, '0); rd("R3 clear lane1", 3'd3, {20'd0, mk_m});
        step(1, 3'd4, 4'h3, 32'hFFF, '0); rd("R3 clear all", 3'd3, 32'h0);
        rd("R9 msk_clr reads 0", 3'd4, 32'h0);

        // Per-source sweep: capture, irq, mask, capture under mask, clear
        step(1, 3'd1, 4'h3, 32'hFFF, '0);
        for (int i = 0; i < 12; i++) begin
            logic [11:0] b;
            b = 12'(1) << i;
            step(0, 3'd0, 4'h0, 32'h0, b);
            rd("R4 capture", 3'd0, {20'd0, st_m});
            irq_chk("R7 irq rises");
            step(1, 3'd3, 4'h3, {20'd0, b}, '0);
            irq_chk("R7 irq masked");
            step(1, 3'd0, 4'h3, {20'd0, b}, '0);
            step(0, 3'd0, 4'h0, 32'h0, b);
            rd("R8 capture under mask", 3'd0, {20'd0, st_m});
            step(1, 3'd0, 4'h3, {20'd0, b}, '0);
            rd("R5 clear", 3'd0, 32'h0);
            step(1, 3'd4, 4'h3, {20'd0, b}, '0);
            irq_chk("R7 irq idle");
        end

        // R4 disabled sources ignored
        step(1, 3'd2, 4'h3, 32'hFFF, '0);
        step(0, 3'd0, 4'h0, 32'h0, 12'hFFF);
        rd("R4 disabled", 3'd0, 32'h0);
        irq_chk("R7 no irq");
        // R4 partial enable
        step(1, 3'd1, 4'h3, 32'hA5A, '0);
        step(0, 3'd0, 4'h0, 32'h0, 12'hFFF);
        rd("R4 partial", 3'd0, {20'd0, st_m});
        // R5 zeros leave bits unchanged, lane gating on clear (R9)
        step(1, 3'd0, 4'h1, 32'hF0F, '0);
        rd("R5 partial clear", 3'd0, {20'd0, st_m});
        step(1, 3'd0, 4'h3, 32'hFFF, '0);
        rd("R5 clear all", 3'd0, 32'h0);
        // R4 enable written in same cycle as event: not captured
        step(1, 3'd1, 4'h3, 32'h001, 12'h001);
        rd("R4 enable same cycle", 3'd0, {20'd0, st_m});
        // R6 collision
        step(1, 3'd1, 4'h3, 32'hFFF, '0);
        step(0, 3'd0, 4'h0, 32'h0, 12'hFFF);
        step(1, 3'd0, 4'h3, 32'hFFF, 12'h803);
        rd("R6 event wins", 3'd0, {20'd0, st_m});
        irq_chk("R7 after collision");
        // R9 upper bits and unused addresses
        step(1, 3'd1, 4'hF, 32'hFFFF_FFFF, '0);
        rd("R9 upper zero", 3'd1, 32'h0000_0FFF);
        for (int a = 4; a < 8; a++) rd("R9 unused addr", 3'(a), 32'h0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule